// File: doc/BRIEF.md
# Two-Stage Four-Operand Summation Pipeline

This block adds four unsigned 12-bit operands and returns their full-precision total. The work is split over two register stages. In the first stage, two 12-bit adders run side by side: one forms the sum of operands A and B, the other the sum of C and D. Each pair sum keeps its carry-out and is registered as a 13-bit value. In the second stage, a third adder merges the two pair sums into a 14-bit total, and that total is registered at the output. A new operand set may enter on every clock, and its total leaves two clocks later. A valid flag travels through the pipeline with the data.

Every adder is made of 4-bit carry-lookahead groups. The lowest group has a fixed carry-in of zero. Each upper group computes its sum twice, once for an incoming carry of zero and once for a carry of one. The real carry from the group below then selects one of the two results, so the carry chain between groups is only a row of multiplexers. Stage two has 13-bit operands, so its top group is one bit wide.

A test-mode input is sampled together with each operand set. When it is high, the output word for that set carries the two registered first-stage pair sums in place of the final total. This lets the first stage be checked on its own, through the same output and with the same latency.

Top module: `quad_sum_pipe`

## Requirements
- R1: `rst` is synchronous and active-high. After a clock edge that samples it high, `out_valid` is 0 and `result` is all zeros. Both stay at zero after the next edge as well, because both pipeline stages are cleared.
- R2: When an operand set is captured with `test_mode` low, `result` equals opnd_a+opnd_b+opnd_c+opnd_d, zero-extended to 26 bits. It appears after the second rising edge following capture.
- R3: The total never overflows. The largest input set (all four operands 4095) gives exactly 16380, and `result` bits 25 down to 14 are zero for every set captured with `test_mode` low.
- R4: After each rising edge, `out_valid` equals the value `in_valid` had two edges earlier, as long as no reset occurred in between.
- R5: An operand set can be captured on every edge. Sets on consecutive edges give correct, independent results on consecutive edges.
- R6: When an operand set is captured with `test_mode` high, `result[25:13]` equals opnd_a+opnd_b and `result[12:0]` equals opnd_c+opnd_d, both as 13-bit values. They appear at the same latency as in R2.
- R7: Carries cross the 4-bit group boundaries (bit 3 to bit 4, bit 7 to bit 8) and leave the top of a 12-bit adder (bit 11 to bit 12) correctly. For example, 0x00F+0x001 gives 0x010, 0x0FF+0x001 gives 0x100, and 0xFFF+0x001 gives 0x1000.
- R8: Stage two carries correctly out of its upper groups, including into bit 13. For example, two pair sums of 0x1000 combine to 0x2000, and two pair sums of 0x1FFE combine to 0x3FFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand set on this edge as valid |
| test_mode | input | 1 | Selects the first-stage view for this operand set |
| opnd_a | input | 12 | Operand A (unsigned) |
| opnd_b | input | 12 | Operand B (unsigned) |
| opnd_c | input | 12 | Operand C (unsigned) |
| opnd_d | input | 12 | Operand D (unsigned) |
| out_valid | output | 1 | The result on this cycle belongs to a valid set |
| result | output | 26 | Zero-extended total, or {A+B, C+D} in test mode |

## Verification
A wrong carry inside any lookahead group, or a wrong select between groups, changes the total by a power of two. This shows on `result` exactly two edges after the operand set that uses that carry path. The sweeps drive sets that force carries across each group boundary, and the test-mode view then shows which of the three adders is at fault. A stuck or skipped pipeline register shows up as a result that lags or leads its set by one cycle, or as an `out_valid` pattern that no longer matches `in_valid` two edges earlier. Back-to-back sets with different values expose this within one cycle.

// File: rtl/quad_sum_pkg.sv
package quad_sum_pkg;

    localparam int OPND_W_DEF = 12;
    localparam int CLA_W_DEF  = 4;

    // number of lookahead groups needed to cover a word
    function automatic int groups_for(input int width, input int grp);
        return (width + grp - 1) / grp;
    endfunction

endpackage

// File: rtl/cla_group.sv
module cla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] gen;
    logic [W-1:0] prp;
    logic [W:0]   cy;

    assign gen = a & b;
    assign prp = a ^ b;

    // every carry is a flat sum of products of generate/propagate terms
    always_comb begin
        cy[0] = cin;
        for (int i = 0; i < W; i++) begin
            logic acc;
            logic term;
            acc  = 1'b0;
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & prp[k];
                end
                acc = acc | term;
            end
            term = cin;
            for (int k = 0; k <= i; k++) begin
                term = term & prp[k];
            end
            cy[i+1] = acc | term;
        end
    end

    assign sum  = prp ^ cy[W-1:0];
    assign cout = cy[W];

endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int WIDTH   = 12,
    parameter int GROUP_W = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH:0]   total
);

    localparam int NG = quad_sum_pkg::groups_for(WIDTH, GROUP_W);

    logic             gc [NG+1];
    logic [WIDTH-1:0] s;

    assign gc[0] = 1'b0;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * GROUP_W;
        localparam int LW = (g == NG - 1) ? (WIDTH - LO) : GROUP_W;

        if (g == 0) begin : g_base
            logic [LW-1:0] s0;
            logic          c0;
            cla_group #(.W(LW)) u_cla (
                .a(a[LO +: LW]), .b(b[LO +: LW]), .cin(1'b0),
                .sum(s0), .cout(c0)
            );
            assign s[LO +: LW] = s0;
            assign gc[g+1]     = c0;
        end else begin : g_sel
            logic [LW-1:0] s_lo;
            logic [LW-1:0] s_hi;
            logic          c_lo;
            logic          c_hi;
            cla_group #(.W(LW)) u_cla_lo (
                .a(a[LO +: LW]), .b(b[LO +: LW]), .cin(1'b0),
                .sum(s_lo), .cout(c_lo)
            );
            cla_group #(.W(LW)) u_cla_hi (
                .a(a[LO +: LW]), .b(b[LO +: LW]), .cin(1'b1),
                .sum(s_hi), .cout(c_hi)
            );
            assign s[LO +: LW] = gc[g] ? s_hi : s_lo;
            assign gc[g+1]     = gc[g] ? c_hi : c_lo;
        end
    end

    assign total = {gc[NG], s};

endmodule

// File: rtl/quad_sum_pipe.sv
module quad_sum_pipe #(
    parameter int OP_W    = quad_sum_pkg::OPND_W_DEF,
    parameter int GROUP_W = quad_sum_pkg::CLA_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    test_mode,
    input  logic [OP_W-1:0]         opnd_a,
    input  logic [OP_W-1:0]         opnd_b,
    input  logic [OP_W-1:0]         opnd_c,
    input  logic [OP_W-1:0]         opnd_d,
    output logic                    out_valid,
    output logic [2*(OP_W+1)-1:0]   result
);

    localparam int PAIR_W = OP_W + 1;
    localparam int SUM_W  = OP_W + 2;
    localparam int RES_W  = 2 * PAIR_W;

    typedef struct packed {
        logic              vld;
        logic              tmode;
        logic [PAIR_W-1:0] ab;
        logic [PAIR_W-1:0] cd;
    } stage1_t;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] res;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [PAIR_W-1:0] sum_ab;
    logic [PAIR_W-1:0] sum_cd;
    logic [SUM_W-1:0]  sum_all;

    // stage one: two pair adders in parallel
    csel_adder #(.WIDTH(OP_W), .GROUP_W(GROUP_W)) u_add_ab (
        .a(opnd_a), .b(opnd_b), .total(sum_ab)
    );
    csel_adder #(.WIDTH(OP_W), .GROUP_W(GROUP_W)) u_add_cd (
        .a(opnd_c), .b(opnd_d), .total(sum_cd)
    );

    // stage two: merge the registered pair sums
    csel_adder #(.WIDTH(PAIR_W), .GROUP_W(GROUP_W)) u_add_fin (
        .a(pipe_q.s1.ab), .b(pipe_q.s1.cd), .total(sum_all)
    );

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1.vld   = in_valid;
        pipe_d.s1.tmode = test_mode;
        pipe_d.s1.ab    = sum_ab;
        pipe_d.s1.cd    = sum_cd;
        pipe_d.s2.vld   = pipe_q.s1.vld;
        pipe_d.s2.res   = pipe_q.s1.tmode ? {pipe_q.s1.ab, pipe_q.s1.cd}
                                          : RES_W'(sum_all);
        if (rst) begin
            pipe_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s2.vld;
    assign result    = pipe_q.s2.res;

endmodule

// File: rtl/quad_sum_pipe_chk.sv
module quad_sum_pipe_chk #(
    parameter int OP_W = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  test_mode,
    input logic [OP_W-1:0]       opnd_a,
    input logic [OP_W-1:0]       opnd_b,
    input logic [OP_W-1:0]       opnd_c,
    input logic [OP_W-1:0]       opnd_d,
    input logic                  out_valid,
    input logic [2*(OP_W+1)-1:0] result
);

    localparam int PAIR_W = OP_W + 1;
    localparam int SUM_W  = OP_W + 2;
    localparam int RES_W  = 2 * PAIR_W;

    logic [PAIR_W-1:0] ref_ab;
    logic [PAIR_W-1:0] ref_cd;
    logic [SUM_W-1:0]  ref_all;
    logic [1:0]        since_rst;
    logic              warm;

    assign ref_ab  = PAIR_W'(opnd_a) + PAIR_W'(opnd_b);
    assign ref_cd  = PAIR_W'(opnd_c) + PAIR_W'(opnd_d);
    assign ref_all = SUM_W'(opnd_a) + SUM_W'(opnd_b) + SUM_W'(opnd_c) + SUM_W'(opnd_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assign warm = (since_rst == 2'd2);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 2))); // R4

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_valid, 2) && !$past(test_mode, 2))
        |-> (result == RES_W'($past(ref_all, 2)))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && !$past(test_mode, 2))
        |-> (result[RES_W-1:SUM_W] == '0)); // R3

    AST_STAGE1_VIEW: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_valid, 2) && $past(test_mode, 2))
        |-> (result == {$past(ref_ab, 2), $past(ref_cd, 2)})); // R6

endmodule

bind quad_sum_pipe quad_sum_pipe_chk #(.OP_W(OP_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .test_mode(test_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .opnd_d(opnd_d),
    .out_valid(out_valid), .result(result)
);

// File: tb/quad_sum_pipe_bench.sv
module quad_sum_pipe_bench;

    localparam int CLK_PERIOD = 10;
    localparam int OPW        = 12;
    localparam int PW         = OPW + 1;
    localparam int RW         = 2 * PW;
    localparam int WATCHDOG   = 200000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           test_mode = 1'b0;
    logic [OPW-1:0] opnd_a = '0;
    logic [OPW-1:0] opnd_b = '0;
    logic [OPW-1:0] opnd_c = '0;
    logic [OPW-1:0] opnd_d = '0;
    logic           out_valid;
    logic [RW-1:0]  result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expectation history: index 0 = last driven set, index 1 = the one before
    logic          h_v   [2];
    logic          h_chk [2];
    logic [RW-1:0] h_res [2];
    string         h_tag [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_sum_pipe u_quad_sum_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .test_mode(test_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .opnd_d(opnd_d),
        .out_valid(out_valid), .result(result)
    );

    task automatic step(input logic r, input logic v, input logic tm,
                        input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                        input logic [OPW-1:0] c, input logic [OPW-1:0] d,
                        input string tag);
        logic [RW-1:0] e;
        @(negedge clk);
        checks++;
        if (out_valid !== h_v[1]) begin
            errors++;
            $display("FAIL %s out_valid actual %b expected %b", h_tag[1], out_valid, h_v[1]);
        end
        if (h_chk[1]) begin
            checks++;
            if (result !== h_res[1]) begin
                errors++;
                $display("FAIL %s result actual %h expected %h", h_tag[1], result, h_res[1]);
            end
        end
        h_v[1] = h_v[0]; h_chk[1] = h_chk[0]; h_res[1] = h_res[0]; h_tag[1] = h_tag[0];
        rst = r; in_valid = v; test_mode = tm;
        opnd_a = a; opnd_b = b; opnd_c = c; opnd_d = d;
        if (r) begin
            h_v[0] = 1'b0; h_chk[0] = 1'b1; h_res[0] = '0; h_tag[0] = "R1";
            h_v[1] = 1'b0; h_chk[1] = 1'b1; h_res[1] = '0; h_tag[1] = "R1";
        end else begin
            if (tm) e = {PW'(a) + PW'(b), PW'(c) + PW'(d)};
            else    e = RW'(a) + RW'(b) + RW'(c) + RW'(d);
            h_v[0] = v; h_chk[0] = v; h_res[0] = e; h_tag[0] = tag;
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            h_v[i] = 1'b0; h_chk[i] = 1'b1; h_res[i] = '0; h_tag[i] = "R1";
        end
        // R1: reset state, held for several cycles
        step(1, 1, 0, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, "R1");
        step(1, 1, 0, 12'h123, 12'h456, 12'h789, 12'hABC, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R2 all zero, R3 all max
        step(0, 1, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 0, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, "R3");
        step(0, 1, 1, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, "R6");
        // R7 group boundary carries in each pair adder
        step(0, 1, 1, 12'h00F, 12'h001, 12'h0FF, 12'h001, "R7");
        step(0, 1, 1, 12'hFFF, 12'h001, 12'h001, 12'h00F, "R7");
        step(0, 1, 1, 12'h001, 12'h0FF, 12'h001, 12'hFFF, "R7");
        step(0, 1, 0, 12'h00F, 12'h001, 12'h000, 12'h000, "R7");
        step(0, 1, 0, 12'h0F8, 12'h008, 12'h000, 12'h000, "R7");
        // R8 stage-two carries out of its upper groups
        step(0, 1, 0, 12'hFFF, 12'h001, 12'hFFF, 12'h001, "R8");
        step(0, 1, 0, 12'hFFF, 12'hFFF, 12'h001, 12'h000, "R8");
        step(0, 1, 0, 12'h800, 12'h800, 12'h7FF, 12'h801, "R8");
        // R4 valid gaps
        step(0, 0, 0, 12'h111, 12'h222, 12'h333, 12'h444, "R4");
        step(0, 1, 0, 12'h111, 12'h222, 12'h333, 12'h444, "R4");
        step(0, 0, 1, 12'h555, 12'h666, 12'h777, 12'h888, "R4");
        step(0, 1, 1, 12'h555, 12'h666, 12'h777, 12'h888, "R6");
        // R5 back-to-back sweep over all values of one operand
        for (int i = 0; i < 4096; i++) begin
            logic [OPW-1:0] a, b, c, d;
            a = OPW'(i);
            b = OPW'(i * 7);
            c = OPW'(4095 - i);
            d = OPW'(i) ^ 12'hA5A;
            step(0, 1, (i % 5) == 0, a, b, c, d, ((i % 5) == 0) ? "R6" : "R5");
        end
        // R2 random sets with random valid and mode
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(0, rv[0] | rv[1], rv[2] & rv[3], OPW'($urandom), OPW'($urandom),
                 OPW'($urandom), OPW'($urandom), "R2");
        end
        // R1 reset in the middle of a stream clears both stages
        step(0, 1, 0, 12'hABC, 12'hDEF, 12'h123, 12'h456, "R5");
        step(1, 1, 0, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R4");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule